// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Stall Controller

This block resolves read-after-write dependences in an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Each cycle it looks at the register numbers and flags of the instructions in decode, execute, memory and write-back. From these it chooses where the two execute-stage ALU operands come from: the register-file read, the memory-stage result, or the write-back result. It also chooses where the store data of a store in the memory stage comes from. The block is purely combinational, and its outputs steer multiplexers that sit in the datapath.

The register file is assumed to pass a write through to a read in the same cycle. A producer therefore has to be bypassed to at most the two instructions that follow it. Store data is checked one stage later than the ALU operands, so a load followed directly by a store of the loaded value needs no stall. The only stall comes from a load whose result is needed by the next instruction in its execute stage. For that case the block holds the program counter and the fetch/decode register and sends a bubble into execute.

Top module: `hz_forward_unit`

## Requirements
- R1: An execute operand select is `01` (memory-stage result) when the memory-stage instruction is valid, writes a register, is not a load, and has a non-zero destination equal to that operand's source register.
- R2: If R1 does not apply, an execute operand select is `10` (write-back value) when the write-back instruction is valid, writes a register, and has a non-zero destination equal to the operand's source register.
- R3: If neither R1 nor R2 applies, an operand select is `00` (register-file read). Two instructions that only read the same register give `00`.
- R4: When the memory stage and the write-back stage both match an operand, the memory stage wins and the select is `01`.
- R5: Register number 0 never produces a bypass select other than `00`, never sets the store-data select, and never causes a stall.
- R6: A stall arises when the decode instruction is valid, the execute instruction is a valid load with a non-zero destination, and that destination equals a decode source register whose use flag is set and which is needed in execute. When it arises, `pc_hold`, `ifid_hold` and `idex_bubble` are all 1; otherwise all three are 0.
- R7: A decode store whose second source is used only as store data causes no stall when that source matches an executing load's destination.
- R8: `sd_fwd` is 1 when the memory-stage instruction is a valid store, and the write-back instruction is valid, writes a register, and has a non-zero destination equal to the store's data register. Otherwise `sd_fwd` is 0.
- R9: A load in the memory stage is never chosen as an execute operand source.
- R10: A decode source whose use flag is low, or a decode slot that is not valid, causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode slot holds an instruction |
| id_rs1 | input | RW | Decode first source register |
| id_rs2 | input | RW | Decode second source register |
| id_rs1_use | input | 1 | Decode reads its first source |
| id_rs2_use | input | 1 | Decode reads its second source |
| id_store | input | 1 | Decode instruction is a store; its second source is the store data |
| ex_valid | input | 1 | Execute slot holds an instruction |
| ex_rs1 | input | RW | Execute first source register |
| ex_rs2 | input | RW | Execute second source register |
| ex_rd | input | RW | Execute destination register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_valid | input | 1 | Memory slot holds an instruction |
| mem_rs2 | input | RW | Memory-stage store data register |
| mem_rd | input | RW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_valid | input | 1 | Write-back slot holds an instruction |
| wb_rd | input | RW | Write-back destination register |
| wb_wr | input | 1 | Write-back instruction writes a register |
| fwd_a | output | 2 | First ALU operand source: 00 register, 01 memory result, 10 write-back |
| fwd_b | output | 2 | Second ALU operand source, same encoding |
| sd_fwd | output | 1 | Store data taken from write-back value |
| pc_hold | output | 1 | Program counter keeps its value |
| ifid_hold | output | 1 | Fetch/decode register keeps its value |
| idex_bubble | output | 1 | Execute receives a bubble with write enables cleared |

## Verification
The hardest case to reach is an operand matched by both the memory and the write-back stage while the memory stage is a load. In that case the select must fall back to write-back, not to the register file. A related hard case is a store in decode that follows a load and has a source flagged as unused. Random stimulus over a register range of only four numbers, including register 0, makes such collisions common. Directed vectors then place each of these combinations, and the load-then-store pairing, explicitly. A behavioural reference compares all six outputs every cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int DEF_RW = 5;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_MEMRES  = 2'b01,
        SRC_WBVAL   = 2'b10
    } byp_sel_t;

    localparam int N_EX_OPS = 2;
endpackage

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int RW = DEF_RW
) (
    input  logic [RW-1:0] src,
    input  logic          mem_valid,
    input  logic          mem_wr,
    input  logic          mem_load,
    input  logic [RW-1:0] mem_rd,
    input  logic          wb_valid,
    input  logic          wb_wr,
    input  logic [RW-1:0] wb_rd,
    output byp_sel_t      sel
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src != ZERO_REG);
        // a load's value is not ready in memory stage; never pick it here
        mem_hit  = src_live && mem_valid && mem_wr && !mem_load && (mem_rd == src);
        wb_hit   = src_live && wb_valid && wb_wr && (wb_rd == src);
    end

    always_comb begin
        unique case ({mem_hit, wb_hit})
            2'b10, 2'b11: sel = SRC_MEMRES;
            2'b01:        sel = SRC_WBVAL;
            default:      sel = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall
    import hz_pkg::*;
#(
    parameter int RW = DEF_RW
) (
    input  logic          id_valid,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_rs1_use,
    input  logic          id_rs2_use,
    input  logic          id_store,
    input  logic          ex_valid,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_load,
    output logic          stall
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    logic load_live;
    logic need1;
    logic need2;

    always_comb begin
        load_live = ex_valid && ex_load && (ex_rd != ZERO_REG);
        need1     = id_rs1_use && (id_rs1 == ex_rd);
        // store data is consumed in memory stage and bypassed there
        need2     = id_rs2_use && !id_store && (id_rs2 == ex_rd);
        stall     = id_valid && load_live && (need1 || need2);
    end
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd
    import hz_pkg::*;
#(
    parameter int RW = DEF_RW
) (
    input  logic          mem_valid,
    input  logic          mem_store,
    input  logic [RW-1:0] mem_rs2,
    input  logic          wb_valid,
    input  logic          wb_wr,
    input  logic [RW-1:0] wb_rd,
    output logic          sd_fwd
);
    localparam logic [RW-1:0] ZERO_REG = '0;

    always_comb begin
        sd_fwd = mem_valid && mem_store && wb_valid && wb_wr &&
                 (wb_rd != ZERO_REG) && (wb_rd == mem_rs2);
    end
endmodule

// File: rtl/hz_forward_unit.sv
module hz_forward_unit
    import hz_pkg::*;
#(
    parameter int RW = DEF_RW
) (
    input  logic          id_valid,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic          id_rs1_use,
    input  logic          id_rs2_use,
    input  logic          id_store,
    input  logic          ex_valid,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_load,
    input  logic          mem_valid,
    input  logic [RW-1:0] mem_rs2,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_wr,
    input  logic          mem_load,
    input  logic          mem_store,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_wr,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          sd_fwd,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble
);
    logic [RW-1:0] op_src [N_EX_OPS];
    byp_sel_t      op_sel [N_EX_OPS];
    logic          stall;

    assign op_src[0] = ex_rs1;
    assign op_src[1] = ex_rs2;

    for (genvar g = 0; g < N_EX_OPS; g++) begin : g_op
        hz_operand_fwd #(.RW(RW)) u_op (
            .src      (op_src[g]),
            .mem_valid(mem_valid),
            .mem_wr   (mem_wr),
            .mem_load (mem_load),
            .mem_rd   (mem_rd),
            .wb_valid (wb_valid),
            .wb_wr    (wb_wr),
            .wb_rd    (wb_rd),
            .sel      (op_sel[g])
        );
    end

    hz_load_stall #(.RW(RW)) u_stall (
        .id_valid  (id_valid),
        .id_rs1    (id_rs1),
        .id_rs2    (id_rs2),
        .id_rs1_use(id_rs1_use),
        .id_rs2_use(id_rs2_use),
        .id_store  (id_store),
        .ex_valid  (ex_valid),
        .ex_rd     (ex_rd),
        .ex_load   (ex_load),
        .stall     (stall)
    );

    hz_store_fwd #(.RW(RW)) u_sd (
        .mem_valid(mem_valid),
        .mem_store(mem_store),
        .mem_rs2  (mem_rs2),
        .wb_valid (wb_valid),
        .wb_wr    (wb_wr),
        .wb_rd    (wb_rd),
        .sd_fwd   (sd_fwd)
    );

    always_comb begin
        fwd_a       = op_sel[0];
        fwd_b       = op_sel[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/hz_forward_unit_chk.sv
module hz_forward_unit_chk #(
    parameter int RW = 5
) (
    input logic          ex_rs1,
    input logic [RW-1:0] ex_rs1_v,
    input logic [RW-1:0] ex_rd,
    input logic          ex_valid,
    input logic          ex_load,
    input logic [RW-1:0] mem_rd,
    input logic [RW-1:0] mem_rs2,
    input logic          mem_load,
    input logic [RW-1:0] wb_rd,
    input logic [1:0]    fwd_a,
    input logic          sd_fwd,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble
);
    logic known;
    always_comb begin
        known = !$isunknown({ex_rs1_v, ex_rd, ex_valid, ex_load, mem_rd, mem_rs2,
                             mem_load, wb_rd, fwd_a, sd_fwd, pc_hold, ifid_hold, idex_bubble});
        if (known) begin
            p_mem_src_match_r1: assert (fwd_a != 2'b01 || (mem_rd == ex_rs1_v && !mem_load))
                else $error("fwd_a memory select without matching non-load producer");
            p_wb_src_match_r2: assert (fwd_a != 2'b10 || wb_rd == ex_rs1_v)
                else $error("fwd_a write-back select without match");
            p_zero_reg_r5: assert (ex_rs1_v != '0 || fwd_a == 2'b00)
                else $error("register 0 bypassed");
            p_stall_bundle_r6: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
                else $error("stall outputs disagree");
            p_stall_cause_r6: assert (!pc_hold || (ex_valid && ex_load && ex_rd != '0))
                else $error("stall without live load in execute");
            p_sd_match_r8: assert (!sd_fwd || (wb_rd == mem_rs2 && wb_rd != '0))
                else $error("store data bypass without match");
            p_no_load_src_r9: assert (!(fwd_a == 2'b01 && mem_load))
                else $error("load chosen as operand source");
        end
    end
    logic unused_bit;
    assign unused_bit = ex_rs1;
endmodule

bind hz_forward_unit hz_forward_unit_chk #(.RW(RW)) u_chk (
    .ex_rs1     (1'b0),
    .ex_rs1_v   (ex_rs1),
    .ex_rd      (ex_rd),
    .ex_valid   (ex_valid),
    .ex_load    (ex_load),
    .mem_rd     (mem_rd),
    .mem_rs2    (mem_rs2),
    .mem_load   (mem_load),
    .wb_rd      (wb_rd),
    .fwd_a      (fwd_a),
    .sd_fwd     (sd_fwd),
    .pc_hold    (pc_hold),
    .ifid_hold  (ifid_hold),
    .idex_bubble(idex_bubble)
);

// File: tb/hz_forward_unit_test.sv
module hz_forward_unit_test;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          id_valid, id_rs1_use, id_rs2_use, id_store;
    logic [RW-1:0] id_rs1, id_rs2;
    logic          ex_valid, ex_load;
    logic [RW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic          mem_valid, mem_wr, mem_load, mem_store;
    logic [RW-1:0] mem_rs2, mem_rd;
    logic          wb_valid, wb_wr;
    logic [RW-1:0] wb_rd;
    logic [1:0]    fwd_a, fwd_b;
    logic          sd_fwd, pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int errors = 0;

    hz_forward_unit #(.RW(RW)) uut (.*);

    task automatic clear_all();
        {id_valid, id_rs1_use, id_rs2_use, id_store} = '0;
        id_rs1 = '0; id_rs2 = '0;
        {ex_valid, ex_load} = '0; ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0;
        {mem_valid, mem_wr, mem_load, mem_store} = '0; mem_rs2 = '0; mem_rd = '0;
        {wb_valid, wb_wr} = '0; wb_rd = '0;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: scan producers youngest first, pick first usable.
    function automatic int model_sel(logic [RW-1:0] r, output string tag);
        int     hits [$];
        hits = {};
        if (r != 0 && mem_valid && mem_wr && !mem_load && mem_rd == r) hits.push_back(1);
        if (r != 0 && wb_valid && wb_wr && wb_rd == r) hits.push_back(2);
        if (hits.size() == 0) begin
            tag = (r == 0) ? "R5" : "R3";
            return 0;
        end
        if (hits.size() == 2) tag = "R4";
        else if (hits[0] == 1) tag = "R1";
        else tag = (mem_load && mem_rd == r) ? "R9" : "R2";
        return hits[0];
    endfunction

    task automatic compare_all();
        string ta, tb2;
        int    ea, eb, esd, est;
        ea  = model_sel(ex_rs1, ta);
        eb  = model_sel(ex_rs2, tb2);
        esd = (mem_valid && mem_store && wb_valid && wb_wr && wb_rd != 0 && wb_rd == mem_rs2) ? 1 : 0;
        est = 0;
        if (id_valid && ex_valid && ex_load && ex_rd != 0) begin
            if (id_rs1_use && id_rs1 == ex_rd) est = 1;
            if (id_rs2_use && !id_store && id_rs2 == ex_rd) est = 1;
        end
        check(ta, "fwd_a", int'(fwd_a), ea);
        check(tb2, "fwd_b", int'(fwd_b), eb);
        check("R8", "sd_fwd", int'(sd_fwd), esd);
        check("R6", "pc_hold", int'(pc_hold), est);
        check("R6", "ifid_hold", int'(ifid_hold), est);
        check("R6", "idex_bubble", int'(idex_bubble), est);
    endtask

    task automatic step();
        @(negedge clk);
        #1 compare_all();
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: idle pipeline gives register-file sources, no stall (R3)
        step();
        check("R3", "idle fwd_a", int'(fwd_a), 0);

        // R1: memory result bypass
        clear_all(); mem_valid = 1; mem_wr = 1; mem_rd = 5'd7; ex_rs1 = 5'd7; step();
        check("R1", "mem bypass a", int'(fwd_a), 1);
        // R4: both stages match, memory wins
        wb_valid = 1; wb_wr = 1; wb_rd = 5'd7; ex_rs2 = 5'd7; step();
        check("R4", "priority b", int'(fwd_b), 1);
        // R9: memory is a load, falls back to write-back (R2)
        mem_load = 1; step();
        check("R9", "load not source", int'(fwd_a), 2);
        // R5: register 0 never bypassed
        clear_all(); mem_valid = 1; mem_wr = 1; wb_valid = 1; wb_wr = 1; step();
        check("R5", "r0 fwd_a", int'(fwd_a), 0);
        // R6: load-use stall on first source
        clear_all(); id_valid = 1; id_rs1_use = 1; id_rs1 = 5'd3;
        ex_valid = 1; ex_load = 1; ex_rd = 5'd3; step();
        check("R6", "load-use stall", int'(pc_hold), 1);
        // R7: store data only: no stall
        id_rs1 = 5'd4; id_rs2 = 5'd3; id_rs2_use = 1; id_store = 1; step();
        check("R7", "store after load", int'(pc_hold), 0);
        // R10: unused source no stall
        id_store = 0; id_rs2_use = 0; step();
        check("R10", "unused src", int'(idex_bubble), 0);
        id_rs2_use = 1; id_valid = 0; step();
        check("R10", "invalid decode", int'(idex_bubble), 0);
        // R5: loaded register 0 never stalls
        id_valid = 1; id_rs1 = 0; id_rs2 = 0; ex_rd = 0; step();
        check("R5", "r0 load", int'(pc_hold), 0);
        // R8: load then store of loaded value, data from write-back
        clear_all(); mem_valid = 1; mem_store = 1; mem_rs2 = 5'd9;
        wb_valid = 1; wb_wr = 1; wb_rd = 5'd9; step();
        check("R8", "store data bypass", int'(sd_fwd), 1);
        wb_rd = 0; mem_rs2 = 0; step();
        check("R5", "r0 store data", int'(sd_fwd), 0);
        // R3: two readers of same register, no writer
        clear_all(); ex_rs1 = 5'd2; ex_rs2 = 5'd2; mem_valid = 1; mem_rd = 5'd2; step();
        check("R3", "read-read", int'(fwd_a), 0);

        // random, small register range for frequent collisions
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            {id_valid, id_rs1_use, id_rs2_use, id_store} = 4'($urandom);
            id_rs1 = RW'($urandom_range(0, 3)); id_rs2 = RW'($urandom_range(0, 3));
            {ex_valid, ex_load} = 2'($urandom);
            ex_rs1 = RW'($urandom_range(0, 3)); ex_rs2 = RW'($urandom_range(0, 3));
            ex_rd = RW'($urandom_range(0, 3));
            {mem_valid, mem_wr, mem_load, mem_store} = 4'($urandom);
            mem_rs2 = RW'($urandom_range(0, 3)); mem_rd = RW'($urandom_range(0, 3));
            {wb_valid, wb_wr} = 2'($urandom);
            wb_rd = RW'($urandom_range(0, 3));
            #1 compare_all();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule